// File: doc/BRIEF.md
# Event Message Timestamp Capture Unit

This block records the time at which precision-time-protocol event messages enter or leave a network port, so that software can compute path delays and clock offsets. It watches a start-of-frame strobe that comes with a direction flag, a message type that has already been decoded, and a per-frame stamp request for outgoing frames. When a frame qualifies, the block copies the free-running seconds and nanoseconds counter into a capture register for that direction. It then raises a status bit, and this status bit can drive the interrupt line.

Each direction has exactly one capture slot. Software reads the nanoseconds word first and then the seconds word. Reading the seconds word frees the slot. If a second qualifying frame arrives while the slot is still full, its time is discarded and a sticky overrun flag records the loss. Interrupt sources are unmasked by writing ones to a set register and masked by writing ones to a separate clear register. Writing zeros to either register changes nothing.

Top module: `ptp_evt_stamp`

## Requirements
- R1: After reset, every capture word, the status word (address 3), the interrupt mask and `irq` are all zero.
- R2: A received frame (`is_tx`=0) of message type t is captured only when bit t of the control word (address 0, bits [15:0]) is set, or when the stamp-all bit (control bit 16) is set.
- R3: An outgoing frame (`is_tx`=1) is captured when `tx_req` is high and its message type is ignored. An outgoing frame with `tx_req` low is never captured.
- R4: A capture stores the `now_sec` and `now_ns` values present at the clock edge where `sof` is sampled, and both fields are loaded in that same edge. Outgoing captures read back at addresses 4 (nanoseconds) and 5 (seconds). Received captures read back at addresses 6 and 7.
- R5: A qualifying frame that arrives while its direction's slot is full leaves the stored time unchanged. It also sets that direction's overrun flag (status bit 2 for outgoing, bit 3 for received). Status bits 0 and 1 are the outgoing and received valid flags.
- R6: Reading the seconds word of a direction clears that direction's valid and overrun flags. Reading the nanoseconds word does not clear them.
- R7: Writing to address 1 sets each mask bit whose write-data bit is one (bit 0 outgoing, bit 1 received). Writing to address 2 clears each mask bit whose write-data bit is one. Zero bits leave the mask unchanged, and both addresses read back the mask.
- R8: `irq` is high exactly when some direction has its valid flag set and its mask bit set.
- R9: Outgoing and received captures use separate state, and an event in one direction does not change the other direction's flags or data.
- R10: When a seconds-word read and a qualifying frame fall in the same cycle for one direction, the new frame is captured. The valid flag stays set and the overrun flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_sec | input | SEC_W | Free-running time, seconds |
| now_ns | input | NS_W | Free-running time, nanoseconds |
| sof | input | 1 | Start-of-frame strobe, one cycle |
| is_tx | input | 1 | 1 = outgoing frame, 0 = received frame |
| msg_type | input | TYPE_W | Decoded message type of the frame |
| tx_req | input | 1 | Stamp request for an outgoing frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on read) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from address |
| irq | output | 1 | Interrupt request |

## Verification
Several rules are checked by assertions on every cycle. A full slot keeps its stored time. A fresh capture holds both time fields of the triggering edge. Overrun is only set against a full slot. A zero write never changes the mask. An interrupt always traces back to a valid, unmasked source. Other behaviour needs the bench's scenarios to show it. These are: the complete message-type filter under several select patterns and the stamp-all mode, the request gating of outgoing frames, clear-on-read and no clear when only the nanoseconds word is read, and the collision of a clearing read with a new frame.

// File: rtl/ptp_evt_stamp.sv
module ptp_evt_stamp #(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int TYPE_W = 4,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEC_W-1:0]  now_sec,
  input  logic [NS_W-1:0]   now_ns,
  input  logic              sof,
  input  logic              is_tx,
  input  logic [TYPE_W-1:0] msg_type,
  input  logic              tx_req,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  localparam int NTYPES = 1 << TYPE_W;

  logic [NTYPES-1:0] rx_sel;
  logic              rx_all;
  logic [1:0]        mask;
  logic [1:0]        vld, ovr, evt, rdclr;
  logic [SEC_W-1:0]  c_sec [2];
  logic [NS_W-1:0]   c_ns  [2];

  assign evt[0]   = sof & is_tx & tx_req;
  assign evt[1]   = sof & ~is_tx & (rx_all | rx_sel[msg_type]);
  assign rdclr[0] = reg_rd & (reg_addr == 3'd5);
  assign rdclr[1] = reg_rd & (reg_addr == 3'd7);
  assign irq      = |(vld & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sel <= '0;
      rx_all <= 1'b0;
      mask   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: begin
          rx_sel <= reg_wdata[NTYPES-1:0];
          rx_all <= reg_wdata[NTYPES];
        end
        3'd1: mask <= mask | reg_wdata[1:0];
        3'd2: mask <= mask & ~reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        c_sec[d] <= '0;
        c_ns[d]  <= '0;
        vld[d]   <= 1'b0;
        ovr[d]   <= 1'b0;
      end else begin
        if (evt[d] && (!vld[d] || rdclr[d])) begin
          c_sec[d] <= now_sec;
          c_ns[d]  <= now_ns;
        end
        vld[d] <= evt[d] | (vld[d] & ~rdclr[d]);
        ovr[d] <= rdclr[d] ? 1'b0 : (ovr[d] | (evt[d] & vld[d]));
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = DW'({rx_all, rx_sel});
      3'd1,
      3'd2:    reg_rdata = DW'(mask);
      3'd3:    reg_rdata = DW'({ovr, vld});
      3'd4:    reg_rdata = DW'(c_ns[0]);
      3'd5:    reg_rdata = DW'(c_sec[0]);
      3'd6:    reg_rdata = DW'(c_ns[1]);
      default: reg_rdata = DW'(c_sec[1]);
    endcase
  end

  p_hold_first_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && vld[0] && !rdclr[0]) |=> ($stable(c_sec[0]) && $stable(c_ns[0])));
  p_hold_first_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && vld[1] && !rdclr[1]) |=> ($stable(c_sec[1]) && $stable(c_ns[1])));
  p_both_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && evt[1] && !vld[1]) |=> (c_sec[1] == $past(now_sec) && c_ns[1] == $past(now_ns)));
  p_tx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !(sof && is_tx && tx_req) && !vld[0]) |=> !vld[0]);
  p_ovr_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !ovr[1]) |=> (!ovr[1] || $past(vld[1])));
  p_zero_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && reg_wr && (reg_addr == 3'd1 || reg_addr == 3'd2) && reg_wdata[1:0] == 2'b00)
      |=> $stable(mask));
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((vld[0] && mask[0]) || (vld[1] && mask[1])));
endmodule

// File: tb/sim_ptp_evt_stamp.sv
module sim_ptp_evt_stamp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] now_sec = '0;
  logic [29:0] now_ns = '0;
  logic        sof = 1'b0, is_tx = 1'b0, tx_req = 1'b0;
  logic [3:0]  msg_type = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  ptp_evt_stamp u0 (.clk, .rst_n, .now_sec, .now_ns, .sof, .is_tx, .msg_type, .tx_req,
    .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata, .irq);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic frame(input logic tx, input logic [3:0] t, input logic req,
                       input logic [31:0] s, input logic [29:0] n);
    @(negedge clk); is_tx = tx; msg_type = t; tx_req = req; now_sec = s; now_ns = n; sof = 1'b1;
    @(negedge clk); sof = 1'b0; now_sec = s + 1; now_ns = n + 5;
  endtask

  initial begin
    logic [31:0] v;
    logic [16:0] cfgs [4];
    cfgs[0] = 17'h00000; cfgs[1] = 17'h0A5C3; cfgs[2] = 17'h0FFFF; cfgs[3] = 17'h10000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd3, v); chk("R1 status", v, 0);
    rd(3'd1, v); chk("R1 mask", v, 0);
    rd(3'd6, v); chk("R1 rx ns", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    for (int c = 0; c < 4; c++) begin
      wr(3'd0, {15'b0, cfgs[c]});
      for (int t = 0; t < 16; t++) begin
        logic hit;
        hit = cfgs[c][16] | cfgs[c][t];
        frame(1'b0, t[3:0], 1'b1, 32'(c * 100 + t), 30'(t * 7 + 3));
        rd(3'd3, v); chk("R2 R9 rx filter status", v, {30'b0, hit, 1'b0});
        if (hit) begin
          rd(3'd6, v); chk("R4 rx ns", v, 32'(t * 7 + 3));
          rd(3'd3, v); chk("R6 ns read keeps valid", v, 32'h2);
          rd(3'd7, v); chk("R4 rx sec", v, 32'(c * 100 + t));
          rd(3'd3, v); chk("R6 sec read clears", v, 0);
        end
      end
    end

    for (int q = 0; q < 2; q++) begin
      for (int t = 0; t < 16; t += 5) begin
        frame(1'b1, t[3:0], q[0], 32'(500 + t), 30'(900 + t));
        rd(3'd3, v); chk("R3 R9 tx gate status", v, {31'b0, q[0]});
        if (q == 1) begin
          rd(3'd4, v); chk("R3 tx ns", v, 32'(900 + t));
          rd(3'd5, v); chk("R3 tx sec", v, 32'(500 + t));
        end
      end
    end

    wr(3'd0, 32'h10000);
    frame(1'b0, 4'd0, 1'b0, 32'd11, 30'd111);
    frame(1'b0, 4'd2, 1'b0, 32'd22, 30'd222);
    rd(3'd3, v); chk("R5 overrun status", v, 32'h0A);
    rd(3'd6, v); chk("R5 first kept ns", v, 111);
    rd(3'd7, v); chk("R5 first kept sec", v, 11);
    rd(3'd3, v); chk("R6 overrun cleared", v, 0);

    wr(3'd1, 32'h1); rd(3'd1, v); chk("R7 set tx", v, 1);
    wr(3'd1, 32'h0); rd(3'd2, v); chk("R7 zero set no effect", v, 1);
    frame(1'b1, 4'd0, 1'b1, 32'd7, 30'd70);
    chk("R8 irq tx", {31'b0, irq}, 1);
    frame(1'b0, 4'd1, 1'b0, 32'd8, 30'd80);
    rd(3'd5, v);
    chk("R8 irq rx masked", {31'b0, irq}, 0);
    wr(3'd1, 32'h2);
    chk("R8 irq rx unmasked", {31'b0, irq}, 1);
    wr(3'd2, 32'h2); rd(3'd1, v); chk("R7 clear rx", v, 1);
    chk("R8 irq after clear", {31'b0, irq}, 0);
    wr(3'd2, 32'h0); rd(3'd1, v); chk("R7 zero clear no effect", v, 1);
    rd(3'd7, v);

    frame(1'b1, 4'd0, 1'b1, 32'd40, 30'd400);
    frame(1'b1, 4'd0, 1'b1, 32'd41, 30'd410);
    @(negedge clk);
    reg_addr = 3'd5; reg_rd = 1'b1;
    is_tx = 1'b1; tx_req = 1'b1; now_sec = 32'd50; now_ns = 30'd500; sof = 1'b1;
    @(negedge clk); reg_rd = 1'b0; sof = 1'b0;
    rd(3'd3, v); chk("R10 collide status", v, 32'h1);
    rd(3'd4, v); chk("R10 collide ns", v, 500);
    rd(3'd5, v); chk("R10 collide sec", v, 50);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule